// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block collects the end-of-transfer events of four DMA channels and turns them into one CPU interrupt request with a trap vector. Each channel has a sticky cause flag. The flag is set by the channel's terminal-count pulse and cleared when software writes a one to it. Each channel also has an enable bit and a 3-bit priority level.

A combinational arbiter picks the enabled, pending channel with the highest level. The result is gated by the CPU's global interrupt enable and its current interrupt level. The accepted winner is then latched into a request/vector pair, which holds until it is acknowledged. The vector is a programmable table base plus a fixed per-channel offset.

Channels 0 and 1 can instead chain their completion into a secondary intelligent-DMA engine. A one-cycle trigger pulse carries channel number 5 or 6 to that engine. The trigger waits while the engine is busy or a previous trigger is still outstanding. The CPU interrupt for that channel is held back until the engine reports completion, and a per-channel option can suppress it even then.

Top module: `dmaIrqRouter`

## Requirements
- R1: A terminal-count pulse on a channel sets its cause flag whether or not its enable bit is 1. A flag set while disabled raises a request as soon as the enable bit is later set.
- R2: Pulsing a channel's causeClr bit clears its flag. If a terminal-count pulse arrives in the same cycle, the flag stays set.
- R3: A channel takes part in arbitration only while its cause flag and enable bit are both 1 and it is not held back by a chained transfer. Clearing the enable bit masks it.
- R4: Among competing channels the highest 3-bit level wins. On equal levels the lower-numbered channel wins.
- R5: The winner is accepted only when cpuIe is 1 and cpuLevel is strictly less than the winner's level.
- R6: irqReq rises on the second clock edge after the cause event and stays high, with irqVector unchanged, until a cycle with irqAck. It is low after the next edge. The acknowledge does not clear the flag, so a still-pending channel raises the request again.
- R7: irqVector is tableBase + 0x58 + 4 × channel. The base resets to 0xC00000 and is loaded from baseWrData in a cycle with baseWrEn.
- R8: An event on channel 0 or 1 whose idmaReqCfg and idmaEnCfg bits are both 1 raises no CPU request. It produces a trigger with idmaChan = 5 for channel 0 and 6 for channel 1. If either bit is 0, the event is handled as a plain interrupt.
- R9: idmaTrig is a one-cycle pulse. It is sent only when idmaBusy is 0 and no earlier trigger still awaits idmaDone. A pending event waits while those conditions fail, and channel 0 is served before channel 1.
- R10: After idmaDone for the outstanding channel, that channel's request is released if its idmaIrqOn bit is 1. Otherwise it stays held back until software clears its cause flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tcEvent | input | NUM_CH | Terminal-count pulse per channel |
| causeClr | input | NUM_CH | Write-1 clear of the cause flags |
| irqEnable | input | NUM_CH | Per-channel interrupt enable |
| irqLevel | input | NUM_CH*LVL_W | Per-channel priority level, channel i in bits [i*LVL_W +: LVL_W] |
| idmaReqCfg | input | NUM_IDMA | Chain request bit for channels 0..NUM_IDMA-1 |
| idmaEnCfg | input | NUM_IDMA | Chain enable bit for channels 0..NUM_IDMA-1 |
| idmaIrqOn | input | NUM_IDMA | Raise the CPU interrupt after chained completion |
| baseWrEn | input | 1 | Load strobe for the trap table base |
| baseWrData | input | ADDR_W | New trap table base |
| cpuIe | input | 1 | CPU global interrupt enable |
| cpuLevel | input | LVL_W | CPU current interrupt level |
| irqAck | input | 1 | Acknowledge of the current request |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVector | output | ADDR_W | Trap vector of the current request |
| idmaBusy | input | 1 | Secondary engine cannot take a trigger |
| idmaDone | input | 1 | Secondary engine finished the chained transfer |
| idmaTrig | output | 1 | One-cycle trigger to the secondary engine |
| idmaChan | output | CHN_W | Channel number sent with the trigger |

## Verification
The bench builds the block with its default parameters: four channels, of which two can be chained, 3-bit levels and 24-bit vectors. With these defaults every level value, including the strictly-less comparison at the top level and three-way ties, is within reach. Both chained trigger numbers and the plain channels 2 and 3 can be exercised in the same run. A per-cycle reference model compares request, vector and trigger outputs during a long random phase. That phase mixes busy stretches, spurious completions, base rewrites and configuration changes. Directed sequences pin down the tie order, the clear-versus-event collision and the suppressed chained interrupt.

// File: rtl/dmaIrqPkg.sv
package dmaIrqPkg;
  typedef struct packed {
    logic irqLoad;
    logic trigFire;
    logic doneHit;
  } ctlStrobes_t;
endpackage

// File: rtl/dmaIrqArbiter.sv
module dmaIrqArbiter #(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0]       req,
  input  logic [NUM_CH*LVL_W-1:0] levels,
  output logic                    found,
  output logic [IDX_W-1:0]        winIdx,
  output logic [LVL_W-1:0]        winLvl
);
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    winLvl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (!found || levels[i*LVL_W +: LVL_W] > winLvl)) begin
        found  = 1'b1;
        winIdx = IDX_W'(i);
        winLvl = levels[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/dmaIrqDatapath.sv
module dmaIrqDatapath
  import dmaIrqPkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int LVL_W         = 3,
  parameter int ADDR_W        = 24,
  parameter int NUM_IDMA      = 2,
  parameter int CHN_W         = 3,
  parameter int IDMA_CH_FIRST = 5,
  parameter int VEC_OFFSET    = 'h58,
  parameter int VEC_STRIDE    = 4,
  parameter logic [ADDR_W-1:0] BASE_RESET = 24'hC00000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       tcEvent,
  input  logic [NUM_CH-1:0]       causeClr,
  input  logic [NUM_CH-1:0]       irqEnable,
  input  logic [NUM_CH*LVL_W-1:0] irqLevel,
  input  logic [NUM_IDMA-1:0]     idmaReqCfg,
  input  logic [NUM_IDMA-1:0]     idmaEnCfg,
  input  logic [NUM_IDMA-1:0]     idmaIrqOn,
  input  logic                    baseWrEn,
  input  logic [ADDR_W-1:0]       baseWrData,
  input  logic                    cpuIe,
  input  logic [LVL_W-1:0]        cpuLevel,
  input  ctlStrobes_t             strobes,
  output logic                    winnerOk,
  output logic                    trigPendAny,
  output logic [ADDR_W-1:0]       irqVector,
  output logic [CHN_W-1:0]        idmaChan
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int IIW   = (NUM_IDMA > 1) ? $clog2(NUM_IDMA) : 1;

  logic [NUM_CH-1:0]   cause;
  logic [NUM_CH-1:0]   held;
  logic [NUM_IDMA-1:0] trigPend;
  logic [IIW-1:0]      trigSel;
  logic [IIW-1:0]      outCh;
  logic [ADDR_W-1:0]   tableBase;
  logic                found;
  logic [IDX_W-1:0]    winIdx;
  logic [LVL_W-1:0]    winLvl;

  // Sticky cause flags: a new event beats a simultaneous clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cause <= '0;
    else       cause <= tcEvent | (cause & ~causeClr);
  end

  always_comb begin
    trigSel = '0;
    for (int k = NUM_IDMA - 1; k >= 0; k--) begin
      if (trigPend[k]) trigSel = IIW'(k);
    end
  end

  assign trigPendAny = |trigPend;

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    if (i < NUM_IDMA) begin : gRouted
      logic routed;
      logic heldQ;
      logic pendQ;
      assign routed = idmaReqCfg[i] & idmaEnCfg[i];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          heldQ <= 1'b0;
          pendQ <= 1'b0;
        end else if (tcEvent[i] && routed) begin
          heldQ <= 1'b1;
          pendQ <= 1'b1;
        end else begin
          if (causeClr[i] || (strobes.doneHit && outCh == IIW'(i) && idmaIrqOn[i]))
            heldQ <= 1'b0;
          if (strobes.trigFire && trigSel == IIW'(i))
            pendQ <= 1'b0;
        end
      end
      assign held[i]     = heldQ;
      assign trigPend[i] = pendQ;
    end else begin : gPlain
      assign held[i] = 1'b0;
    end
  end

  dmaIrqArbiter #(.NUM_CH(NUM_CH), .LVL_W(LVL_W), .IDX_W(IDX_W)) i_arb (
    .req    (cause & irqEnable & ~held),
    .levels (irqLevel),
    .found  (found),
    .winIdx (winIdx),
    .winLvl (winLvl)
  );

  assign winnerOk = found && cpuIe && (cpuLevel < winLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tableBase <= BASE_RESET;
      irqVector <= '0;
      idmaChan  <= '0;
      outCh     <= '0;
    end else begin
      if (baseWrEn) tableBase <= baseWrData;
      if (strobes.irqLoad)
        irqVector <= tableBase + ADDR_W'(VEC_OFFSET) + ADDR_W'(VEC_STRIDE) * ADDR_W'(winIdx);
      if (strobes.trigFire) begin
        idmaChan <= CHN_W'(IDMA_CH_FIRST) + CHN_W'(trigSel);
        outCh    <= trigSel;
      end
    end
  end
endmodule

// File: rtl/dmaIrqControl.sv
module dmaIrqControl
  import dmaIrqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        winnerOk,
  input  logic        irqAck,
  input  logic        trigPendAny,
  input  logic        idmaBusy,
  input  logic        idmaDone,
  output ctlStrobes_t strobes,
  output logic        irqReq,
  output logic        idmaTrig
);
  logic outValid;

  assign strobes.irqLoad  = !irqReq && winnerOk;
  assign strobes.trigFire = !outValid && !idmaBusy && trigPendAny;
  assign strobes.doneHit  = outValid && idmaDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      outValid <= 1'b0;
      idmaTrig <= 1'b0;
    end else begin
      if (strobes.irqLoad)      irqReq <= 1'b1;
      else if (irqReq && irqAck) irqReq <= 1'b0;
      if (strobes.trigFire)     outValid <= 1'b1;
      else if (strobes.doneHit) outValid <= 1'b0;
      idmaTrig <= strobes.trigFire;
    end
  end
endmodule

// File: rtl/dmaIrqRouter.sv
module dmaIrqRouter
  import dmaIrqPkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int LVL_W         = 3,
  parameter int ADDR_W        = 24,
  parameter int NUM_IDMA      = 2,
  parameter int CHN_W         = 3,
  parameter int IDMA_CH_FIRST = 5,
  parameter int VEC_OFFSET    = 'h58,
  parameter int VEC_STRIDE    = 4,
  parameter logic [ADDR_W-1:0] BASE_RESET = 24'hC00000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       tcEvent,
  input  logic [NUM_CH-1:0]       causeClr,
  input  logic [NUM_CH-1:0]       irqEnable,
  input  logic [NUM_CH*LVL_W-1:0] irqLevel,
  input  logic [NUM_IDMA-1:0]     idmaReqCfg,
  input  logic [NUM_IDMA-1:0]     idmaEnCfg,
  input  logic [NUM_IDMA-1:0]     idmaIrqOn,
  input  logic                    baseWrEn,
  input  logic [ADDR_W-1:0]       baseWrData,
  input  logic                    cpuIe,
  input  logic [LVL_W-1:0]        cpuLevel,
  input  logic                    irqAck,
  output logic                    irqReq,
  output logic [ADDR_W-1:0]       irqVector,
  input  logic                    idmaBusy,
  input  logic                    idmaDone,
  output logic                    idmaTrig,
  output logic [CHN_W-1:0]        idmaChan
);
  ctlStrobes_t strobes;
  logic        winnerOk;
  logic        trigPendAny;

  dmaIrqDatapath #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .NUM_IDMA(NUM_IDMA),
    .CHN_W(CHN_W), .IDMA_CH_FIRST(IDMA_CH_FIRST), .VEC_OFFSET(VEC_OFFSET),
    .VEC_STRIDE(VEC_STRIDE), .BASE_RESET(BASE_RESET)
  ) i_dp (
    .clk(clk), .rstN(rstN), .tcEvent(tcEvent), .causeClr(causeClr),
    .irqEnable(irqEnable), .irqLevel(irqLevel), .idmaReqCfg(idmaReqCfg),
    .idmaEnCfg(idmaEnCfg), .idmaIrqOn(idmaIrqOn), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .cpuIe(cpuIe), .cpuLevel(cpuLevel),
    .strobes(strobes), .winnerOk(winnerOk), .trigPendAny(trigPendAny),
    .irqVector(irqVector), .idmaChan(idmaChan)
  );

  dmaIrqControl i_ctl (
    .clk(clk), .rstN(rstN), .winnerOk(winnerOk), .irqAck(irqAck),
    .trigPendAny(trigPendAny), .idmaBusy(idmaBusy), .idmaDone(idmaDone),
    .strobes(strobes), .irqReq(irqReq), .idmaTrig(idmaTrig)
  );
endmodule

// File: rtl/dmaIrqChecker.sv
module dmaIrqChecker #(
  parameter int ADDR_W        = 24,
  parameter int CHN_W         = 3,
  parameter int NUM_IDMA      = 2,
  parameter int IDMA_CH_FIRST = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              irqAck,
  input logic [ADDR_W-1:0] irqVector,
  input logic              cpuIe,
  input logic              idmaTrig,
  input logic              idmaBusy,
  input logic [CHN_W-1:0]  idmaChan
);
  a_r6_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !irqAck |=> irqReq && $stable(irqVector));

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && irqAck |=> !irqReq);

  a_r5_rise_needs_ie: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(cpuIe));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    idmaTrig |=> !idmaTrig);

  a_r9_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    idmaTrig |-> $past(!idmaBusy));

  a_r8_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    idmaTrig |-> (int'(idmaChan) >= IDMA_CH_FIRST && int'(idmaChan) < IDMA_CH_FIRST + NUM_IDMA));
endmodule

bind dmaIrqRouter dmaIrqChecker #(
  .ADDR_W(ADDR_W), .CHN_W(CHN_W), .NUM_IDMA(NUM_IDMA), .IDMA_CH_FIRST(IDMA_CH_FIRST)
) i_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqAck(irqAck), .irqVector(irqVector),
  .cpuIe(cpuIe), .idmaTrig(idmaTrig), .idmaBusy(idmaBusy), .idmaChan(idmaChan)
);

// File: tb/test_dmaIrqRouter.sv
`timescale 1ns/1ps
module test_dmaIrqRouter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  tcEvent = '0, causeClr = '0, irqEnable = '0;
  logic [11:0] irqLevel = '0;
  logic [1:0]  idmaReqCfg = '0, idmaEnCfg = '0, idmaIrqOn = '0;
  logic        baseWrEn = 1'b0;
  logic [23:0] baseWrData = '0;
  logic        cpuIe = 1'b0;
  logic [2:0]  cpuLevel = '0;
  logic        irqAck = 1'b0, idmaBusy = 1'b0, idmaDone = 1'b0;
  logic        irqReq, idmaTrig;
  logic [23:0] irqVector;
  logic [2:0]  idmaChan;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmaIrqRouter i_dmaIrqRouter (
    .clk(clk), .rstN(rstN), .tcEvent(tcEvent), .causeClr(causeClr),
    .irqEnable(irqEnable), .irqLevel(irqLevel), .idmaReqCfg(idmaReqCfg),
    .idmaEnCfg(idmaEnCfg), .idmaIrqOn(idmaIrqOn), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .cpuIe(cpuIe), .cpuLevel(cpuLevel),
    .irqAck(irqAck), .irqReq(irqReq), .irqVector(irqVector),
    .idmaBusy(idmaBusy), .idmaDone(idmaDone), .idmaTrig(idmaTrig),
    .idmaChan(idmaChan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model of the requirements, advanced at each rising edge.
  logic [3:0]  mCause;
  logic [1:0]  mHeld, mPend;
  logic        mOutV, mOutCh, mReq, mTrig;
  logic [23:0] mBase, mVec;
  logic [2:0]  mChan;

  always @(posedge clk) begin : model
    logic [3:0] elig;
    int  w, wl, sel;
    bit  found, ok, fire, hit, routed;
    if (!rstN) begin
      mCause = '0; mHeld = '0; mPend = '0; mOutV = 0; mOutCh = 0;
      mReq = 0; mTrig = 0; mBase = 24'hC00000; mVec = '0; mChan = '0;
    end else begin
      elig  = mCause & irqEnable & ~{2'b00, mHeld};
      found = 0; w = 0; wl = 0;
      for (int i = 0; i < 4; i++) begin
        if (elig[i] && (!found || int'(irqLevel[i*3 +: 3]) > wl)) begin
          found = 1; w = i; wl = int'(irqLevel[i*3 +: 3]);
        end
      end
      ok   = found && cpuIe && (int'(cpuLevel) < wl);
      fire = !mOutV && !idmaBusy && (mPend != 2'b00);
      sel  = mPend[0] ? 0 : 1;
      hit  = mOutV && idmaDone;
      for (int c = 0; c < 2; c++) begin
        routed = idmaReqCfg[c] && idmaEnCfg[c];
        if (tcEvent[c] && routed) begin
          mHeld[c] = 1; mPend[c] = 1;
        end else begin
          if (causeClr[c] || (hit && int'(mOutCh) == c && idmaIrqOn[c])) mHeld[c] = 0;
          if (fire && sel == c) mPend[c] = 0;
        end
      end
      mCause = tcEvent | (mCause & ~causeClr);
      if (mReq) begin
        if (irqAck) mReq = 0;
      end else if (ok) begin
        mReq = 1;
        mVec = mBase + 24'h58 + 24'(4 * w);
      end
      mTrig = fire;
      if (fire) begin
        mChan = 3'(5 + sel); mOutCh = sel[0]; mOutV = 1;
      end else if (hit) begin
        mOutV = 0;
      end
      if (baseWrEn) mBase = baseWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R6 model irqReq", {31'b0, irqReq}, {31'b0, mReq});
      if (mReq) chk("R7 model irqVector", {8'b0, irqVector}, {8'b0, mVec});
      chk("R9 model idmaTrig", {31'b0, idmaTrig}, {31'b0, mTrig});
      if (mTrig) chk("R8 model idmaChan", {29'b0, idmaChan}, {29'b0, mChan});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTc(input logic [3:0] m);
    tcEvent = m; tick(1); tcEvent = '0;
  endtask

  task automatic clrAck(input logic [3:0] m);
    causeClr = m; irqAck = 1'b1; tick(1); causeClr = '0; irqAck = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R6 reset irqReq", irqReq, 0);
    chk("R9 reset idmaTrig", idmaTrig, 0);

    // R1: cause set while disabled, seen once enabled
    cpuIe = 1; cpuLevel = 0; irqLevel = {3'd3, 3'd3, 3'd3, 3'd3};
    pulseTc(4'b0100); tick(2);
    chk("R1 disabled no request", irqReq, 0);
    irqEnable = 4'b0100; tick(2);
    chk("R1 request after enable", irqReq, 1);
    chk("R7 vector ch2", irqVector, 24'hC00060);
    tick(3);
    chk("R6 request held", irqReq, 1);
    chk("R6 vector held", irqVector, 24'hC00060);
    irqAck = 1; tick(1); irqAck = 0;
    chk("R6 dropped after ack", irqReq, 0);
    tick(1);
    chk("R6 re-raised, flag kept", irqReq, 1);
    clrAck(4'b0100); tick(2);
    chk("R2 cleared", irqReq, 0);

    // R2: event beats clear
    tcEvent = 4'b0100; causeClr = 4'b0100; tick(1); tcEvent = '0; causeClr = '0;
    tick(2);
    chk("R2 event wins over clear", irqReq, 1);
    clrAck(4'b0100); tick(2);
    irqEnable = '0;

    // R5: CPU gate
    cpuIe = 0; irqEnable = 4'b0010;
    pulseTc(4'b0010); tick(2);
    chk("R5 ie off", irqReq, 0);
    cpuIe = 1; cpuLevel = 3; tick(2);
    chk("R5 equal level refused", irqReq, 0);
    cpuLevel = 2; tick(2);
    chk("R5 lower cpu level accepted", irqReq, 1);
    chk("R7 vector ch1", irqVector, 24'hC0005C);
    clrAck(4'b0010); cpuLevel = 0; tick(2);

    // R3: masking
    irqEnable = 4'b0000;
    pulseTc(4'b1000); tick(2);
    chk("R3 masked channel", irqReq, 0);
    irqEnable = 4'b0111; tick(2);
    chk("R3 other enables do not unmask", irqReq, 0);
    clrAck(4'b1000); tick(2);

    // R4: priority and ties
    irqLevel = {3'd5, 3'd0, 3'd5, 3'd2}; irqEnable = 4'b1111;
    pulseTc(4'b1011); tick(2);
    chk("R4 tie lower index", irqVector, 24'hC0005C);
    clrAck(4'b0010); tick(2);
    chk("R4 next tie member", irqVector, 24'hC00064);
    clrAck(4'b1000); tick(2);
    chk("R4 lowest level last", irqVector, 24'hC00058);
    clrAck(4'b0001); tick(2);
    chk("R4 none pending", irqReq, 0);

    // R7: base rewrite
    baseWrEn = 1; baseWrData = 24'h100000; tick(1); baseWrEn = 0;
    pulseTc(4'b0001); tick(2);
    chk("R7 new base", irqVector, 24'h100058);
    clrAck(4'b0001); tick(1);
    baseWrEn = 1; baseWrData = 24'hC00000; tick(1); baseWrEn = 0; tick(2);

    // R8/R9/R10: chained transfer on channel 0
    idmaReqCfg = 2'b01; idmaEnCfg = 2'b01; idmaIrqOn = 2'b01; idmaBusy = 1;
    pulseTc(4'b0001); tick(3);
    chk("R9 wait while busy", idmaTrig, 0);
    chk("R8 no cpu request", irqReq, 0);
    idmaBusy = 0; tick(1);
    chk("R9 trigger sent", idmaTrig, 1);
    chk("R8 chan ch0", idmaChan, 5);
    tick(1);
    chk("R9 one-cycle pulse", idmaTrig, 0);
    idmaBusy = 1; tick(2);
    chk("R8 still held back", irqReq, 0);
    idmaDone = 1; idmaBusy = 0; tick(1); idmaDone = 0; tick(2);
    chk("R10 released after done", irqReq, 1);
    chk("R10 vector ch0", irqVector, 24'hC00058);
    clrAck(4'b0001); tick(2);

    // R8: one config bit missing -> plain interrupt
    idmaReqCfg = 2'b11; idmaEnCfg = 2'b01;
    pulseTc(4'b0010); tick(1);
    chk("R8 no trigger without enable", idmaTrig, 0);
    chk("R8 plain request", irqReq, 1);
    chk("R8 plain vector", irqVector, 24'hC0005C);
    clrAck(4'b0010); tick(2);

    // R10: suppressed interrupt on channel 1
    idmaEnCfg = 2'b11; idmaIrqOn = 2'b01;
    pulseTc(4'b0010); tick(1);
    chk("R8 trigger ch1", idmaTrig, 1);
    chk("R8 chan ch1", idmaChan, 6);
    idmaDone = 1; tick(1); idmaDone = 0; tick(3);
    chk("R10 suppressed after done", irqReq, 0);
    clrAck(4'b0010); tick(2);

    // R9: queued events, channel 0 first
    idmaIrqOn = 2'b11; idmaBusy = 1;
    pulseTc(4'b0011); tick(2);
    idmaBusy = 0; tick(1);
    chk("R9 first served ch0", idmaChan, 5);
    idmaBusy = 1; tick(1);
    idmaDone = 1; idmaBusy = 0; tick(1); idmaDone = 0; tick(1);
    chk("R9 second trigger", idmaTrig, 1);
    chk("R9 second served ch1", idmaChan, 6);
    idmaDone = 1; tick(1); idmaDone = 0;
    clrAck(4'b0011); tick(2); clrAck(4'b0011); tick(2);
    idmaReqCfg = 0; idmaEnCfg = 0; idmaIrqOn = 0;

    // Random phase, checked against the model each cycle
    for (int n = 0; n < 4000; n++) begin
      tcEvent  = 4'($urandom & $urandom & $urandom);
      causeClr = 4'($urandom & $urandom & $urandom & $urandom);
      irqAck   = ($urandom % 3) == 0;
      idmaBusy = ($urandom % 4) == 0;
      idmaDone = ($urandom % 6) == 0;
      cpuIe    = ($urandom % 4) != 0;
      cpuLevel = 3'($urandom);
      if ($urandom % 16 == 0) irqEnable = 4'($urandom);
      if ($urandom % 16 == 0) irqLevel = 12'($urandom);
      if ($urandom % 32 == 0) {idmaReqCfg, idmaEnCfg, idmaIrqOn} = 6'($urandom | $urandom);
      baseWrEn   = ($urandom % 64) == 0;
      baseWrData = 24'($urandom);
      tick(1);
    end
    tcEvent = 0; causeClr = 0; irqAck = 0; idmaDone = 0; baseWrEn = 0;
    tick(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule